// File: doc/BRIEF.md
# Core Execution-Mode Switch Controller

This controller chooses between a wide out-of-order execution mode and a highly threaded in-order multithreading mode for one core. The choice follows the number of runnable threads. A low thread count selects out-of-order execution, where a few threads gain from speculation. A high count selects in-order mode, where many threads keep the execution units busy at lower energy.

When the selected mode differs from the present one, the controller stalls fetch and waits for the pipeline to drain. It then saves each architectural register of the outgoing threads into reserved ways of the private second-level cache, one request/acknowledge transaction per register. Next it flips the enables of the renamer, the out-of-order scheduler and the load queue. After that it restores the registers of the incoming threads into the physical register file, again one transaction per register. It requests a rename-table rebuild only when the new mode is out-of-order. Finally it releases fetch and pulses a completion flag.

The cache, the register file contents and the rename tables lie outside this block; they appear only as the handshakes at its ports.

Top module: `mode_switch_ctrl`

## Requirements
- R1: The target mode is out-of-order (`mode_ino`=0) when `active_threads` is at most OOO_MAX (default 2) and in-order (`mode_ino`=1) when it is larger. After a switch, `mode_ino` equals the target computed from the thread count captured when that switch began.
- R2: When the target equals the current mode, no switch starts. `fetch_stall` stays low, no spill, fill or table-update request is raised, and `mode_ino` does not change.
- R3: No spill request is raised before `pipe_empty` has been seen high while `fetch_stall` is high.
- R4: Spilling issues min(captured count, capacity of the old mode) × NREGS transactions. They come in thread-major order, with thread index and then register index ascending from 0. Each transaction is held until `spill_ack`. `spill_way` and `fill_way` carry the reserved-way index SAVE_WAY.
- R5: `rename_en`, `ooo_sched_en` and `ldq_en` are all 1 in out-of-order mode and all 0 in in-order mode. The mode changes after the last spill and before the first fill.
- R6: Filling issues min(captured count, capacity of the new mode) × NREGS transactions, in the same order as spilling. Filling starts only after every spill has finished. The capacity is OOO_MAX for out-of-order mode and INO_MAX (default 8) for in-order mode.
- R7: Exactly one rename-table update request is raised, after the last fill, when the new mode is out-of-order. None is raised when the new mode is in-order.
- R8: `fetch_stall` is high from the cycle after a switch is decided until the switch ends, and it is high whenever any spill, fill or table-update request is high.
- R9: `switch_done` is a one-cycle pulse in the first cycle in which `fetch_stall` is low again after a switch.
- R10: The thread count is sampled only while no switch runs. A change of `active_threads` during a switch does not alter that switch's transaction counts; it is acted on after `switch_done`.
- R11: With at most four cycles per handshake, a switch completes within a bound of 2000 cycles.
- R12: After reset the core is in out-of-order mode with all three unit enables at 1, and `fetch_stall`, all requests and `switch_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active_threads | input | CNT_W | Number of runnable threads |
| pipe_empty | input | 1 | Pipeline holds no in-flight instruction |
| spill_req | output | 1 | Register save request |
| spill_tid | output | TID_W | Thread of the register being saved |
| spill_rid | output | REG_W | Architectural register being saved |
| spill_way | output | WAY_W | Reserved cache way for saved state |
| spill_ack | input | 1 | Save transaction accepted |
| fill_req | output | 1 | Register restore request |
| fill_tid | output | TID_W | Thread of the register being restored |
| fill_rid | output | REG_W | Architectural register being restored |
| fill_way | output | WAY_W | Reserved cache way for restored state |
| fill_ack | input | 1 | Restore transaction accepted |
| rat_upd_req | output | 1 | Rebuild rename tables request |
| rat_upd_ack | input | 1 | Rename tables rebuilt |
| fetch_stall | output | 1 | Hold instruction fetch |
| rename_en | output | 1 | Register renaming enable |
| ooo_sched_en | output | 1 | Out-of-order wakeup/select enable |
| ldq_en | output | 1 | Load queue enable |
| mode_ino | output | 1 | Current mode, 1 = in-order multithreaded |
| switch_done | output | 1 | Switch completed pulse |

## Verification
The hardest situation to reach is a change of the thread count in the middle of a switch. That change must be ignored until the switch finishes and must then start an immediate switch back. The bench waits until it sees `fetch_stall` high, moves `active_threads` across the threshold, and checks the spill and fill counts against the captured value. It then expects a second switch to start on its own. The zero-thread return to out-of-order mode, where both walks are empty and only the table update remains, is also reached on purpose. Acknowledges arrive after pseudo-random delays.

// File: rtl/mswc_pkg.sv
package mswc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DRAIN,
      ST_SPILL,
      ST_RECFG,
      ST_FILL,
      ST_RAT
   } sw_state_t;
endpackage

// File: rtl/mswc_policy.sv
module mswc_policy #(
   parameter int CNT_W   = 4,
   parameter int OOO_MAX = 2
) (
   input  logic [CNT_W-1:0] thread_cnt,
   output logic             want_ino
);
   always_comb want_ino = (int'(thread_cnt) > OOO_MAX);
endmodule

// File: rtl/mswc_walker.sv
module mswc_walker #(
   parameter int CNT_W = 4,
   parameter int TID_W = 3,
   parameter int NREGS = 16,
   parameter int REG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] nthr,
   input  logic             ack,
   output logic             req,
   output logic [TID_W-1:0] tid,
   output logic [REG_W-1:0] rid,
   output logic             done
);
   logic             busy;
   logic             reg_wrap;
   logic [CNT_W-1:0] nthr_q;

   generate
      if (NREGS == 1) begin : g_single
         assign rid      = '0;
         assign reg_wrap = 1'b1;
      end else begin : g_multi
         localparam logic [REG_W-1:0] LAST_R = REG_W'(NREGS - 1);
         logic [REG_W-1:0] r_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             r_q <= '0;
            else if (start)         r_q <= '0;
            else if (busy && ack)   r_q <= (r_q == LAST_R) ? '0 : r_q + 1'b1;
         end
         assign rid      = r_q;
         assign reg_wrap = (r_q == LAST_R);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         tid    <= '0;
         nthr_q <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            tid    <= '0;
            nthr_q <= nthr;
            if (nthr == '0) done <= 1'b1;
            else            busy <= 1'b1;
         end else if (busy && ack && reg_wrap) begin
            if (CNT_W'(tid) + CNT_W'(1) == nthr_q) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               tid <= tid + 1'b1;
            end
         end
      end
   end

   assign req = busy;

   // R4
   hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> (req && $stable(tid) && $stable(rid)));
endmodule

// File: rtl/mode_switch_ctrl.sv
module mode_switch_ctrl
   import mswc_pkg::*;
#(
   parameter int OOO_MAX  = 2,
   parameter int INO_MAX  = 8,
   parameter int NREGS    = 16,
   parameter int WAY_W    = 3,
   parameter int SAVE_WAY = 7,
   localparam int CNT_W   = $clog2(INO_MAX + 1),
   localparam int TID_W   = $clog2(INO_MAX),
   localparam int REG_W   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] active_threads,
   input  logic             pipe_empty,
   output logic             spill_req,
   output logic [TID_W-1:0] spill_tid,
   output logic [REG_W-1:0] spill_rid,
   output logic [WAY_W-1:0] spill_way,
   input  logic             spill_ack,
   output logic             fill_req,
   output logic [TID_W-1:0] fill_tid,
   output logic [REG_W-1:0] fill_rid,
   output logic [WAY_W-1:0] fill_way,
   input  logic             fill_ack,
   output logic             rat_upd_req,
   input  logic             rat_upd_ack,
   output logic             fetch_stall,
   output logic             rename_en,
   output logic             ooo_sched_en,
   output logic             ldq_en,
   output logic             mode_ino,
   output logic             switch_done
);
   localparam logic [CNT_W-1:0] OOO_CAP = CNT_W'(OOO_MAX);
   localparam logic [CNT_W-1:0] INO_CAP = CNT_W'(INO_MAX);

   generate
      if (OOO_MAX < 1 || INO_MAX <= OOO_MAX) begin : g_bad_caps
         $error("mode_switch_ctrl: need 1 <= OOO_MAX < INO_MAX");
      end
      if (NREGS < 1) begin : g_bad_regs
         $error("mode_switch_ctrl: NREGS must be at least 1");
      end
      if (SAVE_WAY < 0 || SAVE_WAY >= (1 << WAY_W)) begin : g_bad_way
         $error("mode_switch_ctrl: SAVE_WAY does not fit WAY_W");
      end
   endgenerate

   sw_state_t        state;
   logic             mode_q;
   logic [CNT_W-1:0] cnt_q;
   logic             want_ino;
   logic             start_sw;
   logic             spill_start, fill_start;
   logic             spill_fin, fill_fin;
   logic [CNT_W-1:0] old_cap, new_cap, spill_n, fill_n;

   mswc_policy #(.CNT_W(CNT_W), .OOO_MAX(OOO_MAX)) u_policy (
      .thread_cnt (active_threads),
      .want_ino   (want_ino)
   );

   always_comb begin
      start_sw    = (state == ST_IDLE) && (want_ino != mode_q);
      spill_start = (state == ST_DRAIN) && pipe_empty;
      fill_start  = (state == ST_RECFG);
      old_cap     = mode_q ? INO_CAP : OOO_CAP;
      new_cap     = mode_q ? OOO_CAP : INO_CAP;
      spill_n     = (cnt_q > old_cap) ? old_cap : cnt_q;
      fill_n      = (cnt_q > new_cap) ? new_cap : cnt_q;
   end

   mswc_walker #(.CNT_W(CNT_W), .TID_W(TID_W), .NREGS(NREGS), .REG_W(REG_W)) u_spill (
      .clk(clk), .rst_n(rst_n), .start(spill_start), .nthr(spill_n), .ack(spill_ack),
      .req(spill_req), .tid(spill_tid), .rid(spill_rid), .done(spill_fin)
   );

   mswc_walker #(.CNT_W(CNT_W), .TID_W(TID_W), .NREGS(NREGS), .REG_W(REG_W)) u_fill (
      .clk(clk), .rst_n(rst_n), .start(fill_start), .nthr(fill_n), .ack(fill_ack),
      .req(fill_req), .tid(fill_tid), .rid(fill_rid), .done(fill_fin)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         mode_q      <= 1'b0;
         cnt_q       <= '0;
         switch_done <= 1'b0;
      end else begin
         switch_done <= 1'b0;
         case (state)
            ST_IDLE:  if (start_sw) begin
                         cnt_q <= active_threads;
                         state <= ST_DRAIN;
                      end
            ST_DRAIN: if (pipe_empty) state <= ST_SPILL;
            ST_SPILL: if (spill_fin) state <= ST_RECFG;
            ST_RECFG: begin
                         mode_q <= ~mode_q;
                         state  <= ST_FILL;
                      end
            ST_FILL:  if (fill_fin) begin
                         if (!mode_q) state <= ST_RAT;
                         else begin
                            state       <= ST_IDLE;
                            switch_done <= 1'b1;
                         end
                      end
            ST_RAT:   if (rat_upd_ack) begin
                         state       <= ST_IDLE;
                         switch_done <= 1'b1;
                      end
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign rat_upd_req  = (state == ST_RAT);
   assign fetch_stall  = (state != ST_IDLE);
   assign mode_ino     = mode_q;
   assign rename_en    = ~mode_q;
   assign ooo_sched_en = ~mode_q;
   assign ldq_en       = ~mode_q;
   assign spill_way    = WAY_W'(SAVE_WAY);
   assign fill_way     = WAY_W'(SAVE_WAY);

   // R1
   mode_matches_snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      switch_done |-> (mode_ino == (cnt_q > OOO_CAP)));
   // R2
   mode_frozen_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fetch_stall |=> $stable(mode_ino));
   // R6
   no_overlap_walks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(spill_req && fill_req));
   // R7
   rat_only_to_ooo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rat_upd_req |-> (!mode_ino && !fill_req));
   // R8
   stall_covers_reqs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (spill_req || fill_req || rat_upd_req) |-> fetch_stall);
   // R9
   done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      switch_done |=> !switch_done);
endmodule

// File: tb/tb_mode_switch_ctrl.sv
module tb_mode_switch_ctrl;
   localparam int OOO_MAX  = 2;
   localparam int INO_MAX  = 8;
   localparam int NREGS    = 4;
   localparam int WAY_W    = 3;
   localparam int SAVE_WAY = 5;
   localparam int BOUND    = 2000;
   localparam int CNT_W    = $clog2(INO_MAX + 1);
   localparam int TID_W    = $clog2(INO_MAX);
   localparam int REG_W    = $clog2(NREGS);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CNT_W-1:0] active_threads = '0;
   logic pipe_empty = 1'b0, spill_ack = 1'b0, fill_ack = 1'b0, rat_upd_ack = 1'b0;
   logic spill_req, fill_req, rat_upd_req, fetch_stall, rename_en, ooo_sched_en, ldq_en;
   logic mode_ino, switch_done;
   logic [TID_W-1:0] spill_tid, fill_tid;
   logic [REG_W-1:0] spill_rid, fill_rid;
   logic [WAY_W-1:0] spill_way, fill_way;

   always #2 clk = ~clk;

   mode_switch_ctrl #(.OOO_MAX(OOO_MAX), .INO_MAX(INO_MAX), .NREGS(NREGS),
                      .WAY_W(WAY_W), .SAVE_WAY(SAVE_WAY)) dut (
      .clk(clk), .rst_n(rst_n), .active_threads(active_threads), .pipe_empty(pipe_empty),
      .spill_req(spill_req), .spill_tid(spill_tid), .spill_rid(spill_rid),
      .spill_way(spill_way), .spill_ack(spill_ack),
      .fill_req(fill_req), .fill_tid(fill_tid), .fill_rid(fill_rid),
      .fill_way(fill_way), .fill_ack(fill_ack),
      .rat_upd_req(rat_upd_req), .rat_upd_ack(rat_upd_ack),
      .fetch_stall(fetch_stall), .rename_en(rename_en), .ooo_sched_en(ooo_sched_en),
      .ldq_en(ldq_en), .mode_ino(mode_ino), .switch_done(switch_done)
   );

   int checks = 0, errors = 0;
   int n_spill = 0, n_fill = 0, n_rat = 0, n_done = 0;
   int exp_spill = 0, exp_fill = 0, drain_lat = 1, drain_cnt = 0;
   int sw_cyc = 0, last_sw = 0;
   bit stall_seen = 0, prev_done = 0, exp_mode = 0, tgt_mode = 0;
   logic [15:0] lfsr = 16'hACE1;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", rq, act, exp);
      end
   endtask

   function automatic int cap(input bit m);
      return m ? INO_MAX : OOO_MAX;
   endfunction

   function automatic int min2(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   // environment: pipeline drain model and handshake responders
   initial begin
      forever begin
         @(negedge clk);
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (switch_done) begin
            n_done++;
            chk(!prev_done, "R9 pulse width", 2, 1);
         end
         prev_done = switch_done;
         if (fetch_stall) begin
            stall_seen = 1;
            sw_cyc++;
            drain_cnt++;
            if (drain_cnt >= drain_lat) pipe_empty = 1'b1;
         end else begin
            if (sw_cyc != 0) last_sw = sw_cyc;
            sw_cyc = 0;
            drain_cnt = 0;
            pipe_empty = 1'b0;
         end
         if ((spill_req || fill_req || rat_upd_req) && !fetch_stall)
            chk(0, "R8 request without stall", 0, 1);
         spill_ack = 1'b0;
         if (spill_req && lfsr[0]) begin
            // R3: spilling only after drain was observed
            chk(pipe_empty, "R3 spill before drain", int'(pipe_empty), 1);
            chk(spill_tid == TID_W'(n_spill / NREGS) && spill_rid == REG_W'(n_spill % NREGS),
                "R4 spill order", int'(spill_tid) * 100 + int'(spill_rid),
                (n_spill / NREGS) * 100 + n_spill % NREGS);
            chk(mode_ino == exp_mode, "R5 mode during spill", int'(mode_ino), int'(exp_mode));
            n_spill++;
            spill_ack = 1'b1;
         end
         fill_ack = 1'b0;
         if (fill_req && lfsr[1]) begin
            chk(n_spill == exp_spill, "R6 fill before spills ended", n_spill, exp_spill);
            chk(fill_tid == TID_W'(n_fill / NREGS) && fill_rid == REG_W'(n_fill % NREGS),
                "R6 fill order", int'(fill_tid) * 100 + int'(fill_rid),
                (n_fill / NREGS) * 100 + n_fill % NREGS);
            chk(mode_ino == tgt_mode && rename_en == !tgt_mode && ooo_sched_en == !tgt_mode
                && ldq_en == !tgt_mode, "R5 config before fill", int'(mode_ino), int'(tgt_mode));
            n_fill++;
            fill_ack = 1'b1;
         end
         rat_upd_ack = 1'b0;
         if (rat_upd_req && lfsr[2]) begin
            chk(n_fill == exp_fill, "R7 table update before fills ended", n_fill, exp_fill);
            n_rat++;
            rat_upd_ack = 1'b1;
         end
      end
   end

   task automatic clear_logs();
      n_spill = 0; n_fill = 0; n_rat = 0; n_done = 0; stall_seen = 0;
   endtask

   task automatic run_case(input int c, input int mid);
      bit tgt;
      int waited;
      @(negedge clk);
      clear_logs();
      drain_lat = 1 + (c % 4);
      active_threads = CNT_W'(c);
      tgt = (c > OOO_MAX);
      if (tgt == exp_mode && !fetch_stall) begin
         repeat (12) @(negedge clk);
         // R2: no switch when target equals present mode
         chk(!stall_seen, "R2 stall without switch", int'(stall_seen), 0);
         chk(n_spill == 0 && n_fill == 0 && n_rat == 0, "R2 requests without switch",
             n_spill + n_fill + n_rat, 0);
         chk(mode_ino == exp_mode, "R1 mode kept", int'(mode_ino), int'(exp_mode));
         return;
      end
      tgt_mode  = tgt;
      exp_spill = min2(c, cap(exp_mode)) * NREGS;
      exp_fill  = min2(c, cap(tgt)) * NREGS;
      waited = 0;
      while (!switch_done && waited < BOUND) begin
         @(negedge clk);
         waited++;
         if (mid >= 0 && fetch_stall) active_threads = CNT_W'(mid);
      end
      chk(switch_done, "R11 switch bound", waited, BOUND);
      chk(last_sw <= BOUND, "R11 stall length", last_sw, BOUND);
      chk(n_spill == exp_spill, "R4 spill count", n_spill, exp_spill);
      chk(n_fill == exp_fill, "R6 fill count", n_fill, exp_fill);
      chk(n_rat == (tgt ? 0 : 1), "R7 table update count", n_rat, tgt ? 0 : 1);
      chk(mode_ino == tgt, "R1 new mode", int'(mode_ino), int'(tgt));
      chk(rename_en == !tgt && ooo_sched_en == !tgt && ldq_en == !tgt, "R5 enables",
          int'(rename_en) + int'(ooo_sched_en) + int'(ldq_en), tgt ? 0 : 3);
      chk(!fetch_stall, "R8 stall released at done", int'(fetch_stall), 0);
      if (mid >= 0)
         chk(n_spill == exp_spill && n_fill == exp_fill, "R10 snapshot held",
             n_spill + n_fill, exp_spill + exp_fill);
      exp_mode = tgt;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12
      chk(!mode_ino && rename_en && ooo_sched_en && ldq_en, "R12 reset mode",
          int'(mode_ino), 0);
      chk(!fetch_stall && !spill_req && !fill_req && !rat_upd_req && !switch_done,
          "R12 reset outputs", int'(fetch_stall), 0);
      chk(spill_way == WAY_W'(SAVE_WAY) && fill_way == WAY_W'(SAVE_WAY), "R4 reserved way",
          int'(spill_way), SAVE_WAY);
      // sweep every count from both modes
      for (int c = 0; c <= INO_MAX + 1; c++) begin
         run_case(c, -1);
         run_case((c <= OOO_MAX) ? INO_MAX + 1 : 0, -1);
         run_case(c, -1);
      end
      // R10: count changes during a switch
      run_case(1, -1);
      run_case(6, 0);
      run_case(0, -1);
      run_case(9, 1);
      run_case(1, -1);
      @(negedge clk);
      chk(!switch_done, "R9 no extra pulse", int'(switch_done), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "watchdog", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule